// File: doc/BRIEF.md
# ATA Status and Device Control Register Block

This block implements the device side of three task-file registers on an ATA-style storage card: the status register, its alternate copy, and the device control register. It also drives the interrupt line to the host. A host reaches the registers over a small strobe bus with a register offset, a read strobe, a write strobe and an 8-bit data path. The card's internal controller supplies its live status flags and a one-cycle interrupt-request pulse.

The returned status byte combines the controller flags with the block's own busy override. Reading the primary status offset acknowledges a pending interrupt. Reading the alternate offset returns the same byte and leaves the interrupt pending. A write to the device control offset sets an active-low interrupt mask and a level-held soft reset. That write is accepted even while the device reports busy. While the soft reset is held, the block reports busy. After the soft reset is released, busy stays set until the controller signals that it is ready.

Top module: `ata_status_ctrl`

## Requirements
- R1: A read strobe at offset 7h returns the status byte on `host_rdata` one clock later. The byte holds BUSY in bit 7, DRDY (`ctl_ready`) in bit 6, write fault in bit 5, seek complete in bit 4, DRQ in bit 3, corrected-data in bit 2 and ERR in bit 0.
- R2: Bit 1 of every returned status byte is 0.
- R3: When the effective busy (controller busy, soft reset held, or post-reset hold) is 1, the returned status byte is exactly 80h.
- R4: A read at offset 7h clears a pending interrupt. A read at offset Eh returns the same byte as offset 7h and leaves the interrupt pending.
- R5: A one-cycle `ctl_irq_req` pulse sets the pending flag. If a request and an offset-7h read fall in the same cycle, the flag stays set.
- R6: `host_intrq` equals the pending flag when device control bit 1 is 0, and is 0 when that bit is 1. Masking does not discard a pending interrupt.
- R7: A write at offset Eh captures data bit 2 (soft reset) and bit 1 (interrupt disable) in the cycle after the strobe, even while the controller is busy. Data bits 7..3 and bit 0 have no effect.
- R8: `soft_rst_o` equals the stored bit 2 for as long as that bit is held. While it is 1, the pending flag is cleared and interrupt requests are ignored.
- R9: After bit 2 is cleared, BUSY stays 1 until `ctl_ready` has been seen high at a clock edge.
- R10: After synchronous reset, `host_rdata` is 00h, `soft_rst_o` is 0, `host_intrq` is 0, and interrupts are enabled.
- R11: A read at any other offset returns 00h and does not change the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 4 | Register offset |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| host_intrq | output | 1 | Interrupt request to host |
| ctl_busy | input | 1 | Controller busy |
| ctl_ready | input | 1 | Controller ready for a command |
| ctl_wfault | input | 1 | Write fault flag |
| ctl_seek_done | input | 1 | Seek complete flag |
| ctl_drq | input | 1 | Data request flag |
| ctl_corr | input | 1 | Corrected data error flag |
| ctl_err | input | 1 | Error flag |
| ctl_irq_req | input | 1 | One-cycle interrupt request pulse |
| soft_rst_o | output | 1 | Soft reset to the controller, held level |

## Verification
The hardest case to reach from the ports is a new interrupt request landing in the same cycle as an acknowledging status read. The flag must survive that cycle. The bench drives the read strobe and the request pulse in the same cycle and then checks that the interrupt line is still high. A second subtle case is the busy hold after soft reset. The bench clears the reset bit while `ctl_ready` is held low, reads busy several times, and only then raises ready to watch BUSY drop. The status byte is swept over all 128 flag combinations on both read offsets, and all 256 control-write values are applied.

// File: rtl/ata_stat_pkg.sv
package ata_stat_pkg;

    localparam int DATA_W        = 8;
    localparam int CTL_SRST_BIT  = 2;
    localparam int CTL_NIEN_BIT  = 1;

    // Status byte as the host sees it, bit 7 first.
    typedef struct packed {
        logic busy;
        logic drdy;
        logic wfault;
        logic seek_done;
        logic drq;
        logic corr;
        logic idx;
        logic err;
    } stat_byte_t;

    // Live flags from the internal controller.
    typedef struct packed {
        logic busy;
        logic ready;
        logic wfault;
        logic seek_done;
        logic drq;
        logic corr;
        logic err;
    } ctl_flags_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_STAT  = 2'd1,
        ACC_ALT   = 2'd2,
        ACC_OTHER = 2'd3
    } rd_kind_e;

    // Builds the host-visible byte; when busy only bit 7 is reported.
    function automatic stat_byte_t pack_status(ctl_flags_t f, logic busy_eff);
        stat_byte_t s;
        s = '0;
        if (busy_eff) begin
            s.busy = 1'b1;
        end else begin
            s.drdy      = f.ready;
            s.wfault    = f.wfault;
            s.seek_done = f.seek_done;
            s.drq       = f.drq;
            s.corr      = f.corr;
            s.err       = f.err;
        end
        s.idx = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/ata_hreg_decode.sv
module ata_hreg_decode
    import ata_stat_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h7,
    parameter logic [ADDR_W-1:0] CTL_OFS  = 'hE
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output rd_kind_e          rd_kind,
    output logic              stat_ack,
    output logic              ctl_wr
);

    always_comb begin
        rd_kind = ACC_NONE;
        if (rd) begin
            if (addr == STAT_OFS)      rd_kind = ACC_STAT;
            else if (addr == CTL_OFS)  rd_kind = ACC_ALT;
            else                       rd_kind = ACC_OTHER;
        end
    end

    assign stat_ack = (rd_kind == ACC_STAT);
    assign ctl_wr   = wr && (addr == CTL_OFS);

endmodule

// File: rtl/ata_devctl_reg.sv
module ata_devctl_reg
    import ata_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ctl_ready,
    output logic              srst,
    output logic              nien,
    output logic              busy_hold
);

    always_ff @(posedge clk) begin
        if (rst) begin
            srst <= 1'b0;
            nien <= 1'b0;
        end else if (ctl_wr) begin
            srst <= wdata[CTL_SRST_BIT];
            nien <= wdata[CTL_NIEN_BIT];
        end
    end

    // Stays set through soft reset and until the controller reports ready.
    always_ff @(posedge clk) begin
        if (rst)             busy_hold <= 1'b0;
        else if (srst)       busy_hold <= 1'b1;
        else if (ctl_ready)  busy_hold <= 1'b0;
    end

    AST_CTL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (srst == $past(wdata[CTL_SRST_BIT])) && (nien == $past(wdata[CTL_NIEN_BIT]))); // R7

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
        (busy_hold && !srst && !ctl_ready) |=> busy_hold); // R9

    AST_HOLD_DURING_SRST: assert property (@(posedge clk) disable iff (rst)
        srst |=> busy_hold); // R8

endmodule

// File: rtl/ata_irq_pend.sv
module ata_irq_pend (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic stat_ack,
    input  logic srst,
    input  logic nien,
    output logic pend,
    output logic intrq
);

    always_ff @(posedge clk) begin
        if (rst)            pend <= 1'b0;
        else if (srst)      pend <= 1'b0;
        else if (req)       pend <= 1'b1;
        else if (stat_ack)  pend <= 1'b0;
    end

    assign intrq = pend & ~nien;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (!srst && req) |=> pend); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!srst && !req && stat_ack) |=> !pend); // R4

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        srst |=> !pend); // R8

    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst)
        (pend && !srst && !stat_ack) |=> pend); // R6

endmodule

// File: rtl/ata_status_ctrl.sv
module ata_status_ctrl
    import ata_stat_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h7,
    parameter logic [ADDR_W-1:0] CTL_OFS  = 'hE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_intrq,
    input  logic              ctl_busy,
    input  logic              ctl_ready,
    input  logic              ctl_wfault,
    input  logic              ctl_seek_done,
    input  logic              ctl_drq,
    input  logic              ctl_corr,
    input  logic              ctl_err,
    input  logic              ctl_irq_req,
    output logic              soft_rst_o
);

    rd_kind_e   rd_kind;
    logic       stat_ack;
    logic       ctl_wr;
    logic       srst;
    logic       nien;
    logic       busy_hold;
    logic       pend;
    logic       intrq;
    ctl_flags_t flags;
    stat_byte_t stat_now;
    logic       busy_eff;

    ata_hreg_decode #(
        .ADDR_W   (ADDR_W),
        .STAT_OFS (STAT_OFS),
        .CTL_OFS  (CTL_OFS)
    ) dec_i (
        .addr     (host_addr),
        .rd       (host_rd),
        .wr       (host_wr),
        .rd_kind  (rd_kind),
        .stat_ack (stat_ack),
        .ctl_wr   (ctl_wr)
    );

    ata_devctl_reg ctl_i (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .wdata     (host_wdata),
        .ctl_ready (ctl_ready),
        .srst      (srst),
        .nien      (nien),
        .busy_hold (busy_hold)
    );

    ata_irq_pend irq_i (
        .clk      (clk),
        .rst      (rst),
        .req      (ctl_irq_req),
        .stat_ack (stat_ack),
        .srst     (srst),
        .nien     (nien),
        .pend     (pend),
        .intrq    (intrq)
    );

    always_comb begin
        flags.busy      = ctl_busy;
        flags.ready     = ctl_ready;
        flags.wfault    = ctl_wfault;
        flags.seek_done = ctl_seek_done;
        flags.drq       = ctl_drq;
        flags.corr      = ctl_corr;
        flags.err       = ctl_err;
    end

    assign busy_eff = ctl_busy | srst | busy_hold;
    assign stat_now = pack_status(flags, busy_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else begin
            case (rd_kind)
                ACC_STAT, ACC_ALT: host_rdata <= stat_now;
                default:           host_rdata <= '0;
            endcase
        end
    end

    assign host_intrq = intrq;
    assign soft_rst_o = srst;

    AST_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        host_rdata[1] == 1'b0); // R2

    AST_BUSY_ONLY: assert property (@(posedge clk) disable iff (rst)
        host_rdata[7] |-> (host_rdata[6:0] == 7'd0)); // R3

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        nien |-> !host_intrq); // R6

    AST_SRST_BUSY: assert property (@(posedge clk) disable iff (rst)
        (soft_rst_o && host_rd && (host_addr == STAT_OFS)) |=> (host_rdata == 8'h80)); // R8

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (host_rdata == 8'h00) && !soft_rst_o && !host_intrq); // R10

endmodule

// File: tb/ata_status_ctrl_tb.sv
module ata_status_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] host_addr;
    logic       host_rd, host_wr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       host_intrq;
    logic       ctl_busy, ctl_ready, ctl_wfault, ctl_seek_done;
    logic       ctl_drq, ctl_corr, ctl_err, ctl_irq_req;
    logic       soft_rst_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ata_status_ctrl dut_i (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_intrq(host_intrq), .ctl_busy(ctl_busy), .ctl_ready(ctl_ready),
        .ctl_wfault(ctl_wfault), .ctl_seek_done(ctl_seek_done), .ctl_drq(ctl_drq),
        .ctl_corr(ctl_corr), .ctl_err(ctl_err), .ctl_irq_req(ctl_irq_req),
        .soft_rst_o(soft_rst_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat(input logic [6:0] f, input logic hold);
        // f = {busy, ready, wfault, seek, drq, corr, err}
        if (f[6] || hold) return 8'h80;
        return {1'b0, f[5], f[4], f[3], f[2], f[1], 1'b0, f[0]};
    endfunction

    task automatic set_flags(input logic [6:0] f);
        {ctl_busy, ctl_ready, ctl_wfault, ctl_seek_done, ctl_drq, ctl_corr, ctl_err} = f;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        host_addr = 4'hE; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic irq_pulse();
        @(negedge clk);
        ctl_irq_req = 1'b1;
        @(negedge clk);
        ctl_irq_req = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        rst = 1'b1; host_addr = '0; host_rd = 0; host_wr = 0; host_wdata = '0;
        ctl_irq_req = 0;
        set_flags(7'b0100000);
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 rdata", host_rdata, 8'h00);
        check("R10 srst", {7'd0, soft_rst_o}, 8'h00);
        check("R10 intrq", {7'd0, host_intrq}, 8'h00);
        rst = 1'b0;
        irq_pulse();
        check("R10 irq enabled after reset", {7'd0, host_intrq}, 8'h01);
        rd(4'h7);

        // R1 R2 R3: sweep all flag combinations on both read offsets
        for (int f = 0; f < 128; f++) begin
            set_flags(f[6:0]);
            rd(4'h7);
            check("R1 R2 R3 status", host_rdata, exp_stat(f[6:0], 1'b0));
            rd(4'hE);
            check("R4 alt equals status", host_rdata, exp_stat(f[6:0], 1'b0));
        end
        set_flags(7'b0100000);

        // R4: alt read keeps pending, status read clears
        irq_pulse();
        rd(4'hE);
        check("R4 alt keeps pending", {7'd0, host_intrq}, 8'h01);
        rd(4'h7);
        check("R4 status clears", {7'd0, host_intrq}, 8'h00);

        // R11: other offsets read zero, no side effect
        irq_pulse();
        for (int a = 0; a < 16; a++) begin
            if (a != 7 && a != 14) begin
                rd(a[3:0]);
                check("R11 other offset data", host_rdata, 8'h00);
                check("R11 pending kept", {7'd0, host_intrq}, 8'h01);
            end
        end
        rd(4'h7);

        // R5: set and acknowledge in the same cycle
        @(negedge clk);
        host_addr = 4'h7; host_rd = 1'b1; ctl_irq_req = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; ctl_irq_req = 1'b0;
        check("R5 set wins over ack", {7'd0, host_intrq}, 8'h01);
        rd(4'h7);
        check("R5 later ack clears", {7'd0, host_intrq}, 8'h00);

        // R6: mask hides but keeps pending
        wr(8'h02);
        irq_pulse();
        check("R6 masked", {7'd0, host_intrq}, 8'h00);
        wr(8'h00);
        check("R6 unmasked pending visible", {7'd0, host_intrq}, 8'h01);
        rd(4'h7);

        // R7 R8: sweep all control values, some while busy
        for (int v = 0; v < 256; v++) begin
            ctl_busy = v[0];
            wr(v[7:0]);
            check("R7 R8 soft reset level", {7'd0, soft_rst_o}, {7'd0, v[2]});
            irq_pulse();
            check("R6 R7 R8 intrq", {7'd0, host_intrq}, {7'd0, !v[2] && !v[1]});
            rd(4'h7);
            check("R3 R8 busy during srst", host_rdata, (v[2] || v[0]) ? 8'h80 : 8'h40);
            ctl_busy = 1'b0;
            wr(8'h00);
            @(negedge clk);
        end

        // R9: busy held after release until ready
        set_flags(7'b0010001);
        wr(8'h04);
        wr(8'h00);
        check("R9 srst released", {7'd0, soft_rst_o}, 8'h00);
        for (int k = 0; k < 3; k++) begin
            rd(4'h7);
            check("R9 busy held", host_rdata, 8'h80);
        end
        @(negedge clk);
        ctl_ready = 1'b1;
        rd(4'h7);
        check("R9 busy drops after ready", host_rdata, 8'h61);

        // R10: reset mid-run restores state
        wr(8'h06);
        irq_pulse();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R10 srst after reset", {7'd0, soft_rst_o}, 8'h00);
        irq_pulse();
        check("R10 enabled after reset", {7'd0, host_intrq}, 8'h01);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule